// File: doc/BRIEF.md
# Sigma-Delta Bitstream Input Sampler

This block is the front end of one channel of a sigma-delta receiver. It accepts the modulator clock line and the modulator data line, both asynchronous to the system clock. It brings them into the system clock domain and finds the edges of the modulator clock. It then hands one data bit, marked by a one-cycle valid strobe, to a downstream decimation filter each time the selected capture rule fires.

Six capture rules are available: rising edge, falling edge, both edges, every second rising edge, every second falling edge, and a Manchester mode. In Manchester mode the clock line is ignored and the bits are recovered from the transitions of the data line alone. Each input has its own bypass bit, which selects the raw pin in place of its synchroniser. A chip with several channels places one copy per channel, and each copy is configured on its own.

Top module: `sds_sampler`

## Requirements
- R1: With mode code 0, each rising modulator-clock edge produces one strobe, and `bit_o` carries the data level seen at that edge.
- R2: With mode code 1, both the rising and the falling modulator-clock edges each produce a strobe that carries the data level at that edge.
- R3: With mode code 3, only falling modulator-clock edges produce strobes.
- R4: Mode code 4 captures on every second rising edge and mode code 5 on every second falling edge. The edge count is cleared while `en_i` is low, so the first qualifying edge after enable is skipped and the second one is captured.
- R5: With mode code 2, a data-line transition from low to high yields bit 1 and one from high to low yields bit 0. A transition that comes fewer than `min_gap_i` system cycles after the last accepted transition is ignored. The first transition after enable is always accepted.
- R6: Each line passes through a two-stage synchroniser unless its bypass bit is 1. A modulator-clock edge driven between system edges produces a strobe after the next system edge when bypassed, and after the third system edge when synchronised.
- R7: Mode codes 6 and 7 produce no strobes.
- R8: While `en_i` is low no strobe is produced.
- R9: `valid_o` is high for exactly one system cycle per capture, and captures from edges two system cycles apart give separate pulses.
- R10: During reset and right after it, `valid_o` and `bit_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Channel enable |
| mode_i | input | 3 | Capture rule code |
| clk_byp_i | input | 1 | 1 selects the raw modulator clock, bypassing its synchroniser |
| dat_byp_i | input | 1 | 1 selects the raw data line, bypassing its synchroniser |
| min_gap_i | input | GAP_W | Manchester minimum spacing, in system cycles, between accepted transitions |
| mclk_i | input | 1 | Modulator clock line |
| mdat_i | input | 1 | Modulator data line |
| bit_o | output | 1 | Captured or decoded data bit |
| valid_o | output | 1 | One-cycle strobe marking a new bit |

## Verification
The single-pulse property assumes that successive transitions on either line are at least two system cycles apart. In Manchester mode it also assumes a minimum spacing of at least two cycles. The stimulus holds every modulator half-period for two or three system cycles, and the Manchester streams use four-cycle half-bits with a spacing setting of six. When the two lines are compared in the same cycle, both bypass bits are set to the same value, so the data line is always stable across the clock edge that samples it. A deliberate two-cycle glitch on the data line checks that short pulses are rejected. The glitch stays within the two-cycle spacing assumed for accepted transitions.

// File: rtl/sds_pkg.sv
package sds_pkg;
  localparam logic [2:0] SM_RISE  = 3'd0;
  localparam logic [2:0] SM_BOTH  = 3'd1;
  localparam logic [2:0] SM_MANCH = 3'd2;
  localparam logic [2:0] SM_FALL  = 3'd3;
  localparam logic [2:0] SM_RISE2 = 3'd4;
  localparam logic [2:0] SM_FALL2 = 3'd5;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/sds_sync.sv
module sds_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic bypass_i,
  output logic lvl_o
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], raw_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign lvl_o = bypass_i ? raw_i : sh_q[STAGES-1];
endmodule

// File: rtl/sds_edge.sv
module sds_edge
  import sds_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  lvl_i,
  output edge_t ev_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  always_comb begin
    ev_o.rise = lvl_i & ~prev_q;
    ev_o.fall = ~lvl_i & prev_q;
  end
endmodule

// File: rtl/sds_alt.sv
module sds_alt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic ev_i,
  output logic fire_o
);
  logic tog_q, tog_d;

  always_comb begin
    tog_d = tog_q;
    if (clr_i)     tog_d = 1'b0;
    else if (ev_i) tog_d = ~tog_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b0;
    else         tog_q <= tog_d;
  end

  assign fire_o = ev_i & tog_q & ~clr_i;

  // R4: after a clear the next edge is never a capture
  p_skip_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !fire_o);
endmodule

// File: rtl/sds_manch.sv
module sds_manch
  import sds_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  edge_t            ev_i,
  input  logic [GAP_W-1:0] min_gap_i,
  output logic             fire_o,
  output logic             bit_o
);
  localparam logic [GAP_W-1:0] TMAX = '1;

  logic [GAP_W-1:0] tmr_q, tmr_d;
  logic             accept;

  assign accept = en_i & (ev_i.rise | ev_i.fall) & (tmr_q >= min_gap_i);

  always_comb begin
    tmr_d = tmr_q;
    if (!en_i)             tmr_d = TMAX;
    else if (accept)       tmr_d = '0;
    else if (tmr_q != TMAX) tmr_d = tmr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tmr_q <= TMAX;
    else         tmr_q <= tmr_d;
  end

  assign fire_o = accept;
  assign bit_o  = ev_i.rise;

  // R5: an accepted transition blocks another one in the following cycle
  p_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_o && min_gap_i >= 2 && en_i) |=> (!fire_o || !$stable(min_gap_i)));
endmodule

// File: rtl/sds_sampler.sv
module sds_sampler
  import sds_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2,
  parameter int GAP_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [2:0]       mode_i,
  input  logic             clk_byp_i,
  input  logic             dat_byp_i,
  input  logic [GAP_W-1:0] min_gap_i,
  input  logic             mclk_i,
  input  logic             mdat_i,
  output logic             bit_o,
  output logic             valid_o
);
  // reset: asserted at once, released after RST_STAGES clocks
  logic [RST_STAGES-1:0] rs_q;
  logic                  rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= '0;
    else         rs_q <= {rs_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n = rs_q[RST_STAGES-1];

  logic  clk_s, dat_s;
  edge_t clk_ev, dat_ev;
  logic  rise2, fall2, m_fire, m_bit;
  logic  fire_c, bit_c;
  logic  valid_q, valid_d, bit_q, bit_d;

  sds_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
    .clk_i(clk_i), .rst_ni(rst_n), .raw_i(mclk_i), .bypass_i(clk_byp_i), .lvl_o(clk_s));
  sds_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
    .clk_i(clk_i), .rst_ni(rst_n), .raw_i(mdat_i), .bypass_i(dat_byp_i), .lvl_o(dat_s));

  sds_edge u_edge_clk (.clk_i(clk_i), .rst_ni(rst_n), .lvl_i(clk_s), .ev_o(clk_ev));
  sds_edge u_edge_dat (.clk_i(clk_i), .rst_ni(rst_n), .lvl_i(dat_s), .ev_o(dat_ev));

  sds_alt u_alt_rise (.clk_i(clk_i), .rst_ni(rst_n), .clr_i(~en_i),
                      .ev_i(clk_ev.rise), .fire_o(rise2));
  sds_alt u_alt_fall (.clk_i(clk_i), .rst_ni(rst_n), .clr_i(~en_i),
                      .ev_i(clk_ev.fall), .fire_o(fall2));

  sds_manch #(.GAP_W(GAP_W)) u_manch (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(en_i), .ev_i(dat_ev),
    .min_gap_i(min_gap_i), .fire_o(m_fire), .bit_o(m_bit));

  always_comb begin
    unique case (mode_i)
      SM_RISE:  fire_c = clk_ev.rise;
      SM_BOTH:  fire_c = clk_ev.rise | clk_ev.fall;
      SM_MANCH: fire_c = m_fire;
      SM_FALL:  fire_c = clk_ev.fall;
      SM_RISE2: fire_c = rise2;
      SM_FALL2: fire_c = fall2;
      default:  fire_c = 1'b0;
    endcase
    bit_c   = (mode_i == SM_MANCH) ? m_bit : dat_s;
    valid_d = en_i & fire_c;
    bit_d   = valid_d ? bit_c : bit_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      bit_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      bit_q   <= bit_d;
    end
  end

  assign valid_o = valid_q;
  assign bit_o   = bit_q;

  // R9: one-cycle strobe, given line edges at least two cycles apart
  p_valid_single_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    valid_q |=> !valid_q);
  // R7: reserved codes stay silent
  p_reserved_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode_i[2:1] == 2'b11) |=> !valid_q);
  // R8: disabled channel stays silent
  p_disabled_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en_i |=> !valid_q);
  // R1: a rising clock edge in mode 0 yields a strobe with the data level
  p_mode0_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en_i && mode_i == SM_RISE && clk_ev.rise) |=> (valid_q && bit_q == $past(dat_s)));
endmodule

// File: tb/sim_sds_sampler.sv
module sim_sds_sampler;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, en, cbyp, dbyp, mclk, mdat;
  logic [2:0] mode;
  logic [7:0] gap;
  logic       bit_o, valid_o;

  sds_sampler u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode),
    .clk_byp_i(cbyp), .dat_byp_i(dbyp), .min_gap_i(gap),
    .mclk_i(mclk), .mdat_i(mdat), .bit_o(bit_o), .valid_o(valid_o));

  int errs = 0, checks = 0;
  bit done = 1'b0;

  logic cap [256];
  int   ncap = 0, adj = 0;
  logic pv = 1'b0;
  always @(negedge clk) begin
    if (valid_o) begin
      cap[ncap % 256] = bit_o;
      ncap++;
      if (pv) adj++;
    end
    pv = valid_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {mode, bypass both, pattern}
  localparam logic [19:0] VEC [10] = '{
    {3'd0, 1'b0, 16'hA5C3}, {3'd0, 1'b1, 16'h3C96},
    {3'd1, 1'b0, 16'hB2E1}, {3'd3, 1'b1, 16'h5A7F},
    {3'd4, 1'b0, 16'hD3B6}, {3'd5, 1'b1, 16'h6E2D},
    {3'd6, 1'b0, 16'hFFFF}, {3'd7, 1'b1, 16'hFFFF},
    {3'd2, 1'b0, 16'h00B4}, {3'd2, 1'b1, 16'h004D}};

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R5";
      3'd3: return "R3";
      3'd4, 3'd5: return "R4";
      default: return "R7";
    endcase
  endfunction

  // expected captures for clock-driven rules; edge j is rising when j is even
  function automatic void model(input logic [2:0] m, input logic [15:0] seq,
                                output int n, output logic [15:0] bits);
    n = 0; bits = '0;
    for (int j = 0; j < 16; j++) begin
      bit r = (j % 2 == 0);
      bit f;
      case (m)
        3'd0: f = r;
        3'd1: f = 1'b1;
        3'd3: f = !r;
        3'd4: f = r && ((j / 2) % 2 == 1);
        3'd5: f = !r && (((j - 1) / 2) % 2 == 1);
        default: f = 1'b0;
      endcase
      if (f) begin bits[n] = seq[j]; n++; end
    end
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_clk(input logic [15:0] seq);
    for (int j = 0; j < 16; j++) begin
      mdat = seq[j];
      cyc(1);
      mclk = ~mclk;
      cyc(2);
    end
  endtask

  task automatic run_manch(input logic [7:0] pat, input bit glitch);
    for (int i = 0; i < 8; i++) begin
      mdat = ~pat[i];
      cyc(4);
      mdat = pat[i];
      if (glitch && i == 2) begin
        cyc(1); mdat = ~pat[i]; cyc(2); mdat = pat[i]; cyc(1);
      end else cyc(4);
    end
  endtask

  task automatic compare(input int base, input int en_n, input logic [15:0] eb,
                         input string req);
    int          cnt = ncap - base;
    logic [15:0] got = '0;
    for (int k = 0; k < cnt && k < 16; k++) got[k] = cap[(base + k) % 256];
    chk(cnt == en_n, req, cnt, en_n);
    chk(got == eb, req, int'(got), int'(eb));
  endtask

  initial begin
    int          base, n, a0;
    logic [15:0] eb;
    logic [2:0]  mv;
    logic        bv;
    logic [15:0] pv16;
    rst_n = 1'b0; en = 1'b0; mode = 3'd0; cbyp = 1'b0; dbyp = 1'b0;
    mclk = 1'b0; mdat = 1'b0; gap = 8'd6;
    cyc(4);
    // R10: outputs low in reset
    chk(valid_o == 1'b0 && bit_o == 1'b0, "R10", {bit_o, valid_o}, 0);
    rst_n = 1'b1;
    cyc(4);
    chk(valid_o == 1'b0 && bit_o == 1'b0, "R10", {bit_o, valid_o}, 0);

    // R6: latency with bypass, then through the synchroniser
    mode = 3'd0; cbyp = 1'b1; dbyp = 1'b1; mdat = 1'b1; en = 1'b1;
    cyc(3);
    mclk = 1'b1;
    cyc(1);
    chk(valid_o == 1'b1 && bit_o == 1'b1, "R6", {bit_o, valid_o}, 3);
    cyc(1);
    chk(valid_o == 1'b0, "R9", valid_o, 0);
    mclk = 1'b0; mdat = 1'b0; cbyp = 1'b0; dbyp = 1'b0;
    cyc(4);
    mclk = 1'b1;
    cyc(1);
    chk(valid_o == 1'b0, "R6", valid_o, 0);
    cyc(1);
    chk(valid_o == 1'b0, "R6", valid_o, 0);
    cyc(1);
    chk(valid_o == 1'b1 && bit_o == 1'b0, "R6", {bit_o, valid_o}, 1);
    mclk = 1'b0;
    cyc(6);
    en = 1'b0;
    cyc(4);

    // table walk
    for (int v = 0; v < 10; v++) begin
      mv = VEC[v][19:17]; bv = VEC[v][16]; pv16 = VEC[v][15:0];
      mode = mv; cbyp = bv; dbyp = bv; mclk = 1'b0;
      if (mv == 3'd2) begin
        mdat = ~pv16[0];
        cyc(8);
        base = ncap; en = 1'b1;
        cyc(2);
        run_manch(pv16[7:0], 1'b0);
        cyc(10);
        en = 1'b0;
        compare(base, 8, {8'h00, pv16[7:0]}, "R5");
      end else begin
        mdat = 1'b0;
        cyc(4);
        base = ncap; en = 1'b1;
        cyc(2);
        run_clk(pv16);
        cyc(8);
        en = 1'b0;
        model(mv, pv16, n, eb);
        compare(base, n, eb, req_of(mv));
      end
      cyc(4);
    end

    // R5: a short glitch after a decoded bit is rejected
    mode = 3'd2; cbyp = 1'b0; dbyp = 1'b0; mdat = 1'b0;
    cyc(8);
    base = ncap; en = 1'b1;
    cyc(2);
    run_manch(8'h71, 1'b1);
    cyc(10);
    en = 1'b0;
    compare(base, 8, 16'h0071, "R5");
    cyc(4);

    // R8: no strobes while disabled
    mode = 3'd1; cbyp = 1'b1; dbyp = 1'b1; mclk = 1'b0;
    base = ncap;
    run_clk(16'hA55A);
    cyc(6);
    chk(ncap == base, "R8", ncap - base, 0);

    // R9: edges two cycles apart give separate pulses
    mclk = 1'b0; en = 1'b1;
    cyc(3);
    base = ncap; a0 = adj;
    for (int k = 0; k < 8; k++) begin
      mdat = k[0]; mclk = ~mclk;
      cyc(2);
    end
    cyc(6);
    en = 1'b0;
    chk(ncap - base == 8, "R9", ncap - base, 8);
    chk(adj == a0, "R9", adj - a0, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule